// File: doc/BRIEF.md
# Mixed Single/Multi-Cycle Execute Stage

This block is the execute slot of an in-order pipeline. It takes the instruction at the head of its input queue, with two operands, an operation code and a flag that marks the operation as long-latency. Short operations (add, subtract, logic, compare, shift, pass) are computed combinationally and leave the stage in the cycle they are presented. Long operations (the low or high half of an unsigned product) go to an internal three-step pipelined multiplier. The stage then sets a waiting flag and keeps its input slot occupied until the multiplier returns the product.

Both edges use a valid/ready pair that behaves like a queue head. The input is dequeued only in the cycle a result is enqueued on the output. The input fields must stay unchanged while the instruction is not dequeued. The tag travels with the instruction to the output, so results leave in program order.

Top module: `mc_exec_stage`

## Requirements
- R1: After the asynchronous reset (rst_ni low) the waiting flag and both multiplier step-valid bits are clear. With no input, out_valid_o and in_ready_o are 0. A short operation presented right after a reset that cut a long operation short completes at once.
- R2: When not waiting and a valid input has in_multi_i=0, out_valid_o is 1 in that same cycle, carrying the result.
- R3: Short operation codes on in_op_i: 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 unsigned less-than (1 or 0), 6 shift a left by b[log2(DATA_W)-1:0], 7 pass b. All results are modulo 2^DATA_W.
- R4: When not waiting and a valid input has in_multi_i=1, a request goes to the multiplier and the stage starts waiting, with no output that cycle. The result appears two cycles after the request cycle. out_valid_o stays 0 in between.
- R5: For long operations in_op_i[0] picks the half of the unsigned 2*DATA_W-bit product a*b: 0 gives the low DATA_W bits, 1 the high DATA_W bits.
- R6: While out_valid_o=1 and out_ready_i=0, nothing is dequeued and out_valid_o and out_data_o stay stable. A long operation keeps waiting with its product held.
- R7: An entry moves from the multiplier's first step register to its second only when the second is empty or is being emptied in that cycle. The response is offered only while the second holds valid data.
- R8: out_tag_o equals the tag of the instruction whose result is on out_data_o.
- R9: in_ready_o is 1 exactly when out_valid_o and out_ready_i are both 1. The waiting flag clears in the cycle a long result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input queue holds an instruction |
| in_ready_o | output | 1 | Dequeue the input instruction |
| in_multi_i | input | 1 | Instruction uses the multi-cycle unit |
| in_op_i | input | 3 | Operation code |
| in_a_i | input | DATA_W | First operand |
| in_b_i | input | DATA_W | Second operand |
| in_tag_i | input | TAG_W | Instruction tag |
| out_valid_o | output | 1 | Result available to enqueue |
| out_ready_i | input | 1 | Output queue can accept |
| out_data_o | output | DATA_W | Result value |
| out_tag_o | output | TAG_W | Tag of the result |

## Verification
The bench goes after the two idle cycles of a long operation. A stage that forgot to set its waiting flag would emit the first-step value or issue twice, and one that dequeued on request would drop the product or pair it with the next tag. Output stalls are placed on both short results and on held products. A design that advanced the multiplier or cleared the waiting flag without a taken result would change or lose the output. An all-ones by all-ones product checks the high half, and a reset in the middle of a wait checks that the flag does not survive and block the next short operation.

// File: rtl/mc_exec_pkg.sv
package mc_exec_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_LTU   = 3'd5,
    OP_SLL   = 3'd6,
    OP_PASSB = 3'd7
  } alu_op_e;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_ADD:   res_o = a_i + b_i;
      OP_SUB:   res_o = a_i - b_i;
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_LTU:   res_o = {{(DATA_W-1){1'b0}}, (a_i < b_i)};
      OP_SLL:   res_o = a_i << b_i[SH_W-1:0];
      default:  res_o = b_i;
    endcase
  end
endmodule

// File: rtl/mc_mul_unit.sv
module mc_mul_unit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_hi_i,
  input  logic [DATA_W-1:0] req_a_i,
  input  logic [DATA_W-1:0] req_b_i,
  output logic              resp_valid_o,
  input  logic              resp_take_i,
  output logic [DATA_W-1:0] resp_data_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned PART_W = DATA_W + HALF_W;
  localparam int unsigned PROD_W = 2 * DATA_W;

  // step one: two partial products
  logic              s1_vld_q;
  logic              s1_hi_q;
  logic [PART_W-1:0] s1_lo_q, s1_up_q;
  // step two: summed product
  logic              s2_vld_q;
  logic              s2_hi_q;
  logic [PROD_W-1:0] s2_prod_q;

  logic              accept, advance, drain;
  logic [PART_W-1:0] part_lo, part_up;
  logic [PROD_W-1:0] prod_sum;

  assign drain       = s2_vld_q && resp_take_i;
  assign advance     = s1_vld_q && (!s2_vld_q || drain);
  assign req_ready_o = !s1_vld_q || advance;
  assign accept      = req_valid_i && req_ready_o;

  assign part_lo = {{HALF_W{1'b0}}, req_a_i} * {{DATA_W{1'b0}}, req_b_i[HALF_W-1:0]};
  assign part_up = {{HALF_W{1'b0}}, req_a_i} * {{DATA_W{1'b0}}, req_b_i[DATA_W-1:HALF_W]};

  assign prod_sum = {{(PROD_W-PART_W){1'b0}}, s1_lo_q}
                  + ({{(PROD_W-PART_W){1'b0}}, s1_up_q} << HALF_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      if (accept)       s1_vld_q <= 1'b1;
      else if (advance) s1_vld_q <= 1'b0;
      if (advance)      s2_vld_q <= 1'b1;
      else if (drain)   s2_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      s1_lo_q <= part_lo;
      s1_up_q <= part_up;
      s1_hi_q <= req_hi_i;
    end
    if (advance) begin
      s2_prod_q <= prod_sum;
      s2_hi_q   <= s1_hi_q;
    end
  end

  // step three: half select as the response is taken
  assign resp_valid_o = s2_vld_q;
  assign resp_data_o  = s2_hi_q ? s2_prod_q[PROD_W-1:DATA_W] : s2_prod_q[DATA_W-1:0];
endmodule

// File: rtl/mc_exec_stage.sv
module mc_exec_stage
  import mc_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_multi_i,
  input  logic [OP_W-1:0]   in_op_i,
  input  logic [DATA_W-1:0] in_a_i,
  input  logic [DATA_W-1:0] in_b_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [TAG_W-1:0]  out_tag_o
);
  logic              wait_q;
  logic              single_done, multi_done, fire;
  logic              req_valid, req_ready, resp_valid;
  logic [DATA_W-1:0] alu_res, mul_res;

  mc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (in_op_i),
    .a_i   (in_a_i),
    .b_i   (in_b_i),
    .res_o (alu_res)
  );

  mc_mul_unit #(.DATA_W(DATA_W)) u_mul (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_hi_i     (in_op_i[0]),
    .req_a_i      (in_a_i),
    .req_b_i      (in_b_i),
    .resp_valid_o (resp_valid),
    .resp_take_i  (multi_done && out_ready_i),
    .resp_data_o  (mul_res)
  );

  assign req_valid   = !wait_q && in_valid_i && in_multi_i;
  assign single_done = !wait_q && in_valid_i && !in_multi_i;
  assign multi_done  = wait_q && resp_valid;

  assign out_valid_o = single_done || multi_done;
  assign out_data_o  = wait_q ? mul_res : alu_res;
  assign out_tag_o   = in_tag_i;
  assign fire        = out_valid_o && out_ready_i;
  assign in_ready_o  = fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     wait_q <= 1'b0;
    else if (req_valid && req_ready) wait_q <= 1'b1;
    else if (wait_q && fire)         wait_q <= 1'b0;
  end
endmodule

// File: rtl/mc_exec_stage_chk.sv
module mc_exec_stage_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_multi_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              wait_q,
  input logic              resp_valid
);
  p_deq_only_on_enq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (out_valid_o && out_ready_i));

  p_hold_on_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && in_valid_i) |=> (out_valid_o && $stable(out_data_o)));

  p_issue_waits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && in_valid_i && in_multi_i) |=> (wait_q && !out_valid_o));

  p_wait_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && out_valid_o && out_ready_i) |=> !wait_q);

  p_single_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && in_valid_i && !in_multi_i) |-> (out_valid_o && !resp_valid));

  p_resp_needs_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid |-> wait_q);
endmodule

bind mc_exec_stage mc_exec_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_multi_i  (in_multi_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .wait_q      (wait_q),
  .resp_valid  (resp_valid)
);

// File: tb/tb_mc_exec_stage.sv
`timescale 1ns/1ps
module tb_mc_exec_stage;
  localparam int DW = 32;
  localparam int TW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0, in_multi_i = 1'b0, out_ready_i = 1'b0;
  logic [2:0]    in_op_i = '0;
  logic [DW-1:0] in_a_i = '0, in_b_i = '0;
  logic [TW-1:0] in_tag_i = '0;
  logic          in_ready_o, out_valid_o;
  logic [DW-1:0] out_data_o;
  logic [TW-1:0] out_tag_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  mc_exec_stage #(.DATA_W(DW), .TAG_W(TW)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic multi, input logic [2:0] op,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    if (multi) begin
      p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
      return op[0] ? p[2*DW-1:DW] : p[DW-1:0];
    end
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return (a < b) ? 1 : 0;
      3'd6: return a << b[4:0];
      default: return b;
    endcase
  endfunction

  // present one instruction until it is dequeued; ready_pct sets out_ready_i odds
  task automatic run_instr(input logic multi, input logic [2:0] op, input logic [DW-1:0] a,
                           input logic [DW-1:0] b, input logic [TW-1:0] tag, input int ready_pct);
    int cnt = 0;
    bit fired = 0;
    logic exp_v;
    while (!fired && !done) begin
      @(negedge clk_i);
      in_valid_i  = 1'b1;
      in_multi_i  = multi;
      in_op_i     = op;
      in_a_i      = a;
      in_b_i      = b;
      in_tag_i    = tag;
      out_ready_i = (($urandom % 100) < ready_pct);
      #1;
      exp_v = !multi || (cnt >= 2);
      chk(multi ? "R4 valid timing" : "R2 same-cycle valid", out_valid_o, exp_v);
      chk("R9 dequeue with enqueue", in_ready_o, exp_v && out_ready_i);
      if (out_valid_o) begin
        chk(multi ? "R5 product half" : "R3 short op", out_data_o, model(multi, op, a, b));
        chk("R8 tag", out_tag_o, tag);
        if (!out_ready_i) chk("R6 held under stall", out_valid_o, 1'b1);
      end
      fired = in_ready_o;
      cnt++;
      @(posedge clk_i);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i  = 1'b0;
      out_ready_i = $urandom % 2;
      #1;
      chk("R1 no output without input", out_valid_o, 1'b0);
      chk("R9 no dequeue without input", in_ready_o, 1'b0);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 reset out_valid", out_valid_o, 1'b0);
    chk("R1 reset in_ready", in_ready_o, 1'b0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(2);

    // directed corners
    run_instr(1'b1, 3'd1, '1, '1, 4'h1, 100);           // R5 high half FFFFFFFE
    run_instr(1'b1, 3'd0, '1, '1, 4'h2, 100);           // R5 low half 00000001
    run_instr(1'b1, 3'd0, 32'h0001_0000, 32'h0001_0000, 4'h3, 0 + 100);
    run_instr(1'b0, 3'd1, 32'd0, 32'd1, 4'h4, 100);     // R3 wrap
    run_instr(1'b0, 3'd5, 32'd3, 32'd7, 4'h5, 100);     // R3 ltu
    run_instr(1'b0, 3'd6, 32'h1, 32'd31, 4'h6, 100);    // R3 shift max
    run_instr(1'b1, 3'd1, 32'h1234_5678, 32'h9abc_def0, 4'h7, 20); // R6 R7 stall on product
    run_instr(1'b0, 3'd0, 32'h5, 32'h6, 4'h8, 20);      // R6 stall on short op

    // R1: reset in the middle of a wait
    @(negedge clk_i);
    in_valid_i = 1'b1; in_multi_i = 1'b1; in_op_i = 3'd0;
    in_a_i = 32'd9; in_b_i = 32'd9; out_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b0;
    in_valid_i = 1'b0;
    #1;
    chk("R1 reset clears output", out_valid_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    run_instr(1'b0, 3'd7, 32'd0, 32'hcafe_f00d, 4'h9, 100); // completes at once
    idle(1);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic m;
      logic [DW-1:0] a, b;
      m = ($urandom % 3) == 0;
      a = ($urandom % 8 == 0) ? '1 : $urandom;
      b = ($urandom % 8 == 0) ? '0 : $urandom;
      run_instr(m, 3'($urandom), a, b, TW'(k), 40 + ($urandom % 61));
      if ($urandom % 5 == 0) idle(1 + ($urandom % 3));
      if (done) break;
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule